// File: doc/BRIEF.md
# Microsecond Tick Divider

This block turns a fast system clock into a one-cycle enable pulse at a fixed lower rate, normally one pulse per microsecond. A serial bus timing engine uses the pulse to advance its own slot counters. Software picks the rate by writing one 8-bit configuration byte.

The division ratio is not a plain binary count. It is the product of two factors: an odd factor chosen by a 2-bit field and a power of two chosen by a 3-bit field. Two cascaded counters carry it out. The first counter divides by the power of two. The second counts prescaler wraps until it reaches the odd factor.

Every write of the configuration byte clears both counters, so the new rate begins from a clean period. Software maps clock frequency to code before it writes; the block itself does no lookup.

Top module: `usec_tick_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `tick` is low, and the captured configuration reads as disabled.
- R2: Bit 7 of the configuration byte is the enable. While the captured bit 7 is 0, `tick` stays low and both counters are held at zero.
- R3: Bits 1:0 select the odd factor. The values 0, 1, 2 and 3 select 1, 3, 5 and 7.
- R4: Bits 4:2 hold a value n that selects a prescale of 2^n, for n from 0 to 7.
- R5: The total ratio R is the odd factor times the prescale. When enabled, `tick` is high exactly once in every R cycles. This holds up to the largest code 0x9F, which gives R = 7 × 128 = 896.
- R6: A cycle with `cfg_wr` high captures `cfg_data` and clears both counters. This holds even in the middle of a period. The first tick then comes in the R-th cycle after the write edge, and ticks repeat every R cycles after that.
- R7: `tick` is exactly one clock wide whenever R > 1. When R = 1 it is high in every enabled cycle.
- R8: Bits 6:5 of the configuration byte have no effect on the tick stream. For example, 0xE5 behaves like 0x85.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_data | input | 8 | Configuration byte: enable, prescale select, odd select |
| tick | output | 1 | One-cycle enable pulse at the divided rate |

## Verification
The hard cases are the longest period and a rewrite that lands partway through a period. Both depend on counter state that the ports never show directly. The stimulus runs code 0x9F for several full 896-cycle periods, so the wrap of both counters is seen more than once. It also rewrites the same code, and then a different code, some dozens of cycles into a period. The reference model then shows whether the restart drops the partial count or carries it over.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;

    localparam int ODD_W  = 2;                // odd-factor select width
    localparam int POW_W  = 3;                // prescale select width
    localparam int PRE_W  = (2 ** POW_W) - 1; // prescale counter width
    localparam int ODD_CW = ODD_W + 1;        // odd counter width

    typedef struct packed {
        logic             en;
        logic [1:0]       spare;
        logic [POW_W-1:0] pow;
        logic [ODD_W-1:0] odd;
    } div_cfg_t;

    // last count of the prescaler: 2^p - 1
    function automatic logic [PRE_W-1:0] pre_last(input logic [POW_W-1:0] p);
        return (PRE_W'(1) << p) - PRE_W'(1);
    endfunction

    // last count of the odd stage: (2*s+1) - 1
    function automatic logic [ODD_CW-1:0] odd_last(input logic [ODD_W-1:0] s);
        return {s, 1'b0};
    endfunction

endpackage

// File: rtl/usec_tick_cfg_reg.sv
module usec_tick_cfg_reg
    import usec_tick_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  logic [7:0] din,
    output div_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (wr) cfg <= div_cfg_t'(din);
    end
endmodule

// File: rtl/usec_tick_prescale.sv
module usec_tick_prescale #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] last,
    output logic         wrap
);
    logic [W-1:0] cnt;

    assign wrap = en && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr || !en) cnt <= '0;
        else if (wrap)         cnt <= '0;
        else                   cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/usec_tick_odd_stage.sv
module usec_tick_odd_stage #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic         fire
);
    logic [W-1:0] cnt;

    assign fire = en && step && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr || !en) cnt <= '0;
        else if (step) begin
            if (cnt == last) cnt <= '0;
            else             cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
    import usec_tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_data,
    output logic       tick
);
    div_cfg_t          cfg_q;
    logic              pre_wrap;
    logic [PRE_W-1:0]  pre_lim;
    logic [ODD_CW-1:0] odd_lim;

    assign pre_lim = pre_last(cfg_q.pow);
    assign odd_lim = odd_last(cfg_q.odd);

    usec_tick_cfg_reg u_cfg (
        .clk (clk),
        .rst (rst),
        .wr  (cfg_wr),
        .din (cfg_data),
        .cfg (cfg_q)
    );

    usec_tick_prescale #(.W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (cfg_wr),
        .en   (cfg_q.en),
        .last (pre_lim),
        .wrap (pre_wrap)
    );

    usec_tick_odd_stage #(.W(ODD_CW)) u_odd (
        .clk  (clk),
        .rst  (rst),
        .clr  (cfg_wr),
        .en   (cfg_q.en),
        .step (pre_wrap),
        .last (odd_lim),
        .fire (tick)
    );
endmodule

// File: rtl/usec_tick_chk.sv
module usec_tick_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr,
    input logic [7:0] din,
    input logic       en,
    input logic [2:0] pow,
    input logic [1:0] odd,
    input logic       tick
);
    int unsigned ratio;
    int unsigned wr_ratio;
    logic [15:0] gap;

    assign ratio    = (2 * int'(odd) + 1) << pow;
    assign wr_ratio = (2 * int'(din[1:0]) + 1) << din[4:2];

    // cycles since the last restart or tick, kept independently of the counters
    always_ff @(posedge clk) begin
        if (rst || wr)  gap <= '0;
        else if (!en)   gap <= '0;
        else if (tick)  gap <= '0;
        else            gap <= gap + 16'd1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !tick && !en);

    p_disabled_silent_r2: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tick);

    p_period_r5: assert property (@(posedge clk) disable iff (rst)
        en |-> (tick == (32'(gap) == ratio - 1)));

    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && (!din[7] || wr_ratio != 1)) |=> !tick);

    p_single_wide_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr && ratio != 1) |=> !tick);

    p_unity_every_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        (en && ratio == 1) |-> tick);
endmodule

bind usec_tick_gen usec_tick_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .wr   (cfg_wr),
    .din  (cfg_data),
    .en   (cfg_q.en),
    .pow  (cfg_q.pow),
    .odd  (cfg_q.odd),
    .tick (tick)
);

// File: tb/usec_tick_gen_tb.sv
module usec_tick_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic       tick;

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // behavioural reference: cycle count within the period
    int m_en = 0, m_ratio = 1, m_cnt = 0;

    usec_tick_gen u_dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .tick     (tick)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_cnt = 0; m_ratio = 1;
        end else if (cfg_wr) begin
            m_en    = int'(cfg_data[7]);
            m_ratio = (2 * int'(cfg_data[1:0]) + 1) * (1 << cfg_data[4:2]);
            m_cnt   = 0;
        end else if (m_en != 0) begin
            m_cnt = (m_cnt + 1) % m_ratio;
        end
    end

    task automatic compare();
        int exp_t;
        exp_t = (m_en != 0 && m_cnt == m_ratio - 1) ? 1 : 0;
        n_vec++;
        if (int'(tick) !== exp_t) begin
            n_fail++;
            $display("FAIL %s cycle %0d: tick=%0d expected %0d", cur_req, n_vec, tick, exp_t);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic write_cfg(input logic [7:0] code, input string req, input int n);
        @(negedge clk);
        compare();
        cur_req  = req;
        cfg_wr   = 1'b1;
        cfg_data = code;
        @(negedge clk);
        compare();
        cfg_wr   = 1'b0;
        cfg_data = 8'h00;
        run(n);
    endtask

    initial begin
        @(posedge clk);
        cur_req = "R1";
        run(3);                         // R1: quiet in reset
        rst = 1'b0;
        run(20);                        // R1/R2: cleared config, no ticks
        write_cfg(8'h80, "R7", 12);     // R7: ratio 1, every cycle
        write_cfg(8'h81, "R3", 30);     // R3: odd 3
        write_cfg(8'h82, "R3", 30);     // R3: odd 5
        write_cfg(8'h83, "R3", 40);     // R3: odd 7
        write_cfg(8'h84, "R4", 20);     // R4: 2^1
        write_cfg(8'h88, "R4", 30);     // R4: 2^2
        write_cfg(8'h8C, "R4", 50);     // R4: 2^3
        write_cfg(8'h90, "R4", 70);     // R4: 2^4
        write_cfg(8'h9C, "R4", 400);    // R4: 2^7 = 128
        write_cfg(8'h8D, "R5", 100);    // R5: 3 x 8 = 24
        write_cfg(8'h9F, "R5", 2800);   // R5: 7 x 128 = 896
        write_cfg(8'h1F, "R2", 300);    // R2: enable clear, silent
        write_cfg(8'hE5, "R8", 60);     // R8: spare bits ignored, ratio 6
        write_cfg(8'h9C, "R6", 60);     // R6: restart mid-period
        write_cfg(8'h9C, "R6", 300);
        write_cfg(8'h8D, "R6", 10);
        write_cfg(8'h83, "R6", 40);     // R6: change code mid-period
        write_cfg(8'h8A, "R7", 80);     // R7: 5 x 4 = 20, single-wide
        write_cfg(8'h03, "R2", 50);     // R2: disable again
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule